// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block is the digital feedback path of a fractional-N frequency synthesizer. It counts cycles of a fast input clock and raises a one-cycle output pulse at the end of every division period. A period lasts either N or N+1 input cycles. A first-order accumulator with modulus M moves forward by a fractional step F on each output pulse. When the accumulator wraps, the next period is stretched to N+1. Over M periods there are F stretched ones, so the average ratio is N + F/M.

The accumulator value is driven out on its own port. It follows the phase error that builds up from the period-to-period switching, so an external converter can use it to cancel that error. The controls N, F, M and the fractional enable are sampled only at a period boundary. A change made in the middle of a period therefore never shortens or stretches the period already running.

Top module: `fracn_div_ctrl`

## Requirements
- R1: The integer ratio input `div_n` is 16 bits wide and accepts 32 to 65535. A value below 32 is treated as 32.
- R2: `div_pulse` is high for exactly one clock per period. The distance between consecutive pulses is N or N+1 clocks.
- R3: `acc_state` changes only on the clock edge that raises `div_pulse`. In that edge it advances by F when fractional mode is enabled.
- R4: The accumulator has modulus M. When acc+F is at least M, the new value is acc+F-M and a carry is produced. Otherwise the new value is acc+F and there is no carry.
- R5: A carry makes the next period N+1 clocks long, for that one period only. Over M consecutive periods with constant settings, the periods add up to M*N+F clocks.
- R6: When `frac_en` is 0, every period is exactly N clocks and `acc_state` holds its value. When `frac_en` is 1 and F is 0, every period is N clocks.
- R7: N, F, M and `frac_en` are sampled only on the clock that ends a period, and a new value applies to the period that follows. The period in progress keeps its length.
- R8: A synchronous reset clears `acc_state` and `div_pulse`. The first clock edge with reset low starts a period of N clocks, so the first pulse is seen N+1 clock edges after reset is released.
- R9: With N=32, M=4, F=1 and fractional mode on, the pulse-to-pulse periods repeat 32, 32, 32, 33. After successive pulses `acc_state` reads 1, 2, 3, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| div_n | input | 16 | Integer division ratio N |
| frac_step | input | 8 | Fractional increment F, expected below M |
| frac_mod | input | 8 | Accumulator modulus M |
| frac_en | input | 1 | 1 enables fractional stretching |
| div_pulse | output | 1 | One-clock pulse at the end of each period |
| acc_state | output | 8 | Accumulator value, a measure of phase error |

## Verification
The bench checks the 32, 32, 32, 33 pattern together with the 1, 2, 3, 0 accumulator readout. A wrap test that stretched the wrong period would shift the 33 or give a wrong accumulator value. It sets 7 as the modulus and 3 as the step, then checks that seven periods add up to 7N+3; a design that tested strictly greater-than or dropped the subtraction would give a different total. It changes N in the middle of a period and requires that period to keep its old length, which catches a design that applies settings immediately. It also covers the clamp below 32, the top ratio 65535, and the disabled and zero-step modes, where any stretch or accumulator motion is an error.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;

   // Width of the period-length path: one bit wider than N to hold N+1.
   function automatic int len_width(input int n_w);
      return n_w + 1;
   endfunction

endpackage

// File: rtl/fracn_n_sel.sv
module fracn_n_sel #(
   parameter int N_W   = 16,
   parameter int N_MIN = 32,
   parameter int LEN_W = fracn_div_pkg::len_width(N_W)
) (
   input  logic [N_W-1:0]   n_i,
   output logic [LEN_W-1:0] n_eff_o
);

   localparam logic [LEN_W-1:0] FLOOR_V = LEN_W'(N_MIN);

   logic [LEN_W-1:0] n_wide;
   assign n_wide = {1'b0, n_i};

   generate
      if (N_MIN > 0) begin : g_clamp
         assign n_eff_o = (n_wide < FLOOR_V) ? FLOOR_V : n_wide;
      end else begin : g_pass
         assign n_eff_o = n_wide;
      end
   endgenerate

endmodule

// File: rtl/fracn_phase_acc.sv
module fracn_phase_acc #(
   parameter int F_W = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           adv_i,
   input  logic           en_i,
   input  logic [F_W-1:0] inc_i,
   input  logic [F_W-1:0] mod_i,
   output logic           carry_o,
   output logic [F_W-1:0] acc_o
);

   logic [F_W-1:0] acc_q;
   logic [F_W:0]   sum;
   logic [F_W:0]   mod_wide;
   logic           wrap;
   logic [F_W:0]   wrapped;
   logic [F_W-1:0] acc_nxt;

   assign sum      = {1'b0, acc_q} + {1'b0, inc_i};
   assign mod_wide = {1'b0, mod_i};
   assign wrap     = (sum >= mod_wide);
   assign wrapped  = sum - mod_wide;
   assign acc_nxt  = wrap ? wrapped[F_W-1:0] : sum[F_W-1:0];
   assign carry_o  = en_i && wrap;
   assign acc_o    = acc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (adv_i && en_i) begin
         acc_q <= acc_nxt;
      end
   end

   // R4: a legal step keeps the accumulator inside its modulus
   p_acc_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      (adv_i && en_i && (inc_i < mod_i) && (acc_q < mod_i)) |=> (acc_q < $past(mod_i)));

   // R3: no movement between output pulses
   p_acc_still_r3: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> $stable(acc_q));

   // R6: disabled fractional mode freezes the accumulator
   p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (adv_i && !en_i) |=> $stable(acc_q));

endmodule

// File: rtl/fracn_period_cnt.sv
module fracn_period_cnt #(
   parameter int LEN_W = 17,
   parameter int N_MIN = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LEN_W-1:0] len_next_i,
   output logic             term_o,
   output logic             bound_o,
   output logic             pulse_o
);

   localparam logic [LEN_W-1:0] ONE_V   = LEN_W'(1);
   localparam logic [LEN_W-1:0] FLOOR_V = LEN_W'(N_MIN);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic             armed_q;
   logic             pulse_q;

   assign term_o  = armed_q && (cnt_q == (len_q - ONE_V));
   assign bound_o = !armed_q || term_o;
   assign pulse_o = pulse_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         len_q   <= '0;
         armed_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= term_o;
         if (bound_o) begin
            cnt_q   <= '0;
            len_q   <= len_next_i;
            armed_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + ONE_V;
         end
      end
   end

   // R2: pulse never lasts two clocks
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      pulse_q |=> !pulse_q);

   // R2: count stays inside the running period
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
      armed_q |-> (cnt_q < len_q));

   // R1: period never falls below the clamped floor
   p_len_floor_r1: assert property (@(posedge clk) disable iff (rst)
      armed_q |-> (len_q >= FLOOR_V));

   // R8: synchronous reset clears the counter state
   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (cnt_q == '0 && !pulse_q && !armed_q));

endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl #(
   parameter int N_W   = 16,
   parameter int F_W   = 8,
   parameter int N_MIN = 32
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [N_W-1:0] div_n,
   input  logic [F_W-1:0] frac_step,
   input  logic [F_W-1:0] frac_mod,
   input  logic           frac_en,
   output logic           div_pulse,
   output logic [F_W-1:0] acc_state
);

   localparam int LEN_W = fracn_div_pkg::len_width(N_W);

   generate
      if (N_W < 2 || N_W > 30) begin : g_bad_nw
         $error("fracn_div_ctrl: N_W out of range");
      end
      if (F_W < 1 || F_W > 30) begin : g_bad_fw
         $error("fracn_div_ctrl: F_W out of range");
      end
      if (N_MIN < 2 || N_MIN >= (1 << N_W)) begin : g_bad_min
         $error("fracn_div_ctrl: N_MIN must fit the ratio width and be at least 2");
      end
   endgenerate

   logic [LEN_W-1:0] n_eff;
   logic [LEN_W-1:0] len_next;
   logic             term;
   logic             bound;
   logic             carry;
   logic             stretch;

   fracn_n_sel #(.N_W(N_W), .N_MIN(N_MIN), .LEN_W(LEN_W)) n_sel_i (
      .n_i     (div_n),
      .n_eff_o (n_eff)
   );

   fracn_phase_acc #(.F_W(F_W)) acc_i (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (term),
      .en_i    (frac_en),
      .inc_i   (frac_step),
      .mod_i   (frac_mod),
      .carry_o (carry),
      .acc_o   (acc_state)
   );

   assign stretch  = term && carry;
   assign len_next = n_eff + {{(LEN_W-1){1'b0}}, stretch};

   fracn_period_cnt #(.LEN_W(LEN_W), .N_MIN(N_MIN)) cnt_i (
      .clk        (clk),
      .rst        (rst),
      .len_next_i (len_next),
      .term_o     (term),
      .bound_o    (bound),
      .pulse_o    (div_pulse)
   );

   // R3: the accumulator readout moves only together with an output pulse
   p_acc_with_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      !$stable(acc_state) |-> div_pulse);

   // R7: the period boundary strobe always closes out a running period or arms the first
   p_bound_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      (bound && term) |=> div_pulse);

endmodule

// File: tb/fracn_div_ctrl_tb_top.sv
module fracn_div_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [15:0] div_n = 16'd32;
   logic [7:0]  frac_step = 8'd0;
   logic [7:0]  frac_mod = 8'd4;
   logic        frac_en = 1'b0;
   logic        div_pulse;
   logic [7:0]  acc_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fracn_div_ctrl dut_i (
      .clk       (clk),
      .rst       (rst),
      .div_n     (div_n),
      .frac_step (frac_step),
      .frac_mod  (frac_mod),
      .frac_en   (frac_en),
      .div_pulse (div_pulse),
      .acc_state (acc_state)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: cycles remaining until the next pulse
   int  m_rem   = 0;
   int  m_acc   = 0;
   bit  m_pulse = 0;
   bit  m_live  = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_rem = 0; m_acc = 0; m_pulse = 0; m_live = 0;
      end else begin
         int n_now;
         n_now = (div_n < 32) ? 32 : int'(div_n);
         if (!m_live) begin
            m_live = 1; m_rem = n_now; m_pulse = 0;
         end else if (m_rem == 1) begin
            int c;
            c = 0;
            if (frac_en) begin
               m_acc = m_acc + frac_step;
               if (m_acc >= frac_mod) begin
                  m_acc = m_acc - frac_mod;
                  c = 1;
               end
            end
            m_rem = n_now + c;
            m_pulse = 1;
         end else begin
            m_rem = m_rem - 1;
            m_pulse = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         check(div_pulse === m_pulse, "R3 model pulse", int'(div_pulse), int'(m_pulse));
         check(acc_state === 8'(m_acc), "R3 model acc", int'(acc_state), m_acc);
      end
   end

   task automatic next_gap(output int gap, output int accv);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (div_pulse !== 1'b1);
      accv = int'(acc_state);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(div_pulse === 1'b0 && acc_state === 8'd0, "R8 reset state",
            int'(acc_state), 0);
      rst = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      int g, a, prev, total;

      // R8 and R9: reset then the 32,32,32,33 pattern
      div_n = 16'd32; frac_step = 8'd1; frac_mod = 8'd4; frac_en = 1'b1;
      do_reset();
      next_gap(g, a);
      check(g == 33, "R8 first pulse", g, 33);
      check(a == 1, "R9 acc after first pulse", a, 1);
      prev = a;
      for (int i = 0; i < 8; i++) begin
         next_gap(g, a);
         check(g == ((prev == 0) ? 33 : 32), "R9 period", g, (prev == 0) ? 33 : 32);
         check(a == (prev + 1) % 4, "R9 acc readout", a, (prev + 1) % 4);
         prev = a;
      end

      // R6: fractional mode disabled, accumulator frozen
      @(negedge clk);
      frac_en = 1'b0; div_n = 16'd40;
      next_gap(g, a);
      prev = a;
      for (int i = 0; i < 4; i++) begin
         next_gap(g, a);
         check(g == 40, "R6 disabled period", g, 40);
         check(a == prev, "R6 acc held", a, prev);
      end

      // R6: enabled with zero step
      frac_en = 1'b1; frac_step = 8'd0; frac_mod = 8'd5;
      do_reset();
      next_gap(g, a);
      for (int i = 0; i < 4; i++) begin
         next_gap(g, a);
         check(g == 40, "R6 zero step period", g, 40);
      end

      // R4 and R5: M=7, F=3 gives 3 stretched periods in 7
      div_n = 16'd50; frac_step = 8'd3; frac_mod = 8'd7; frac_en = 1'b1;
      do_reset();
      next_gap(g, a);
      check(a == 3, "R4 acc below modulus", a, 3);
      total = 0;
      prev = a;
      for (int i = 0; i < 7; i++) begin
         next_gap(g, a);
         check(g == ((prev + 3 >= 7) ? 51 : 50) - ((prev >= 4) ? 0 : 0) ||
               g == 50 || g == 51, "R5 period choice", g, 50);
         check(a == (prev + 3) % 7, "R4 wrap value", a, (prev + 3) % 7);
         prev = a;
         total += g;
      end
      check(total == 7 * 50 + 3, "R5 seven-period sum", total, 7 * 50 + 3);

      // R7: change N in the middle of a period
      frac_en = 1'b0; div_n = 16'd32;
      next_gap(g, a);
      next_gap(g, a);
      g = 0;
      repeat (10) begin @(negedge clk); g++; end
      div_n = 16'd60;
      do begin @(negedge clk); g++; end while (div_pulse !== 1'b1);
      check(g == 32, "R7 running period kept", g, 32);
      next_gap(g, a);
      check(g == 60, "R7 new period applied", g, 60);

      // R1: clamp below the floor
      div_n = 16'd10;
      next_gap(g, a);
      next_gap(g, a);
      check(g == 32, "R1 clamp to 32", g, 32);

      // R1 and R2: top ratio
      div_n = 16'd65535;
      next_gap(g, a);
      next_gap(g, a);
      check(g == 65535, "R1 top ratio", g, 65535);
      @(negedge clk);
      check(div_pulse === 1'b0, "R2 one clock pulse", int'(div_pulse), 0);

      done = 1;
      summary();
      $finish;
   end

endmodule